// File: doc/BRIEF.md
# Multicast Net Membership Filter

The filter decides whether an arriving multicast cell is taken in. Each cell carries an 8-bit multicast net number. The filter looks that number up in a 256-bit membership bitmap: bit n set means net n is wanted. Control cells always consult one dedicated control bitmap. Data cells consult a per-port data bitmap, chosen from the cell's port number and two configuration inputs. For every lookup request, the decision (accept or reject) comes back one clock later, together with a valid strobe.

A host port reads and writes the bitmaps one 16-bit word at a time. A host address is `{bank, word}`:
- Bank 0 is the control bitmap.
- Bank b+1 is data bitmap b, for b from 0 to 15.
- Inside a bank, word w holds nets 16w to 16w+15, with net 16w+i at bit i.

The configuration inputs select three data arrangements:
- With `cfg_full` high, every one of the 16 ports owns its own data bitmap.
- With `cfg_full` low (compact mode), only data bitmaps 0 to 7 exist, and the upper half of the data space is dead.
- In compact mode, `cfg_pair` high selects a 16-port arrangement in which ports 2k and 2k+1 share data bitmap k.

After reset the block wipes all bitmaps by itself before it raises `ready`. A controller with two states does this:
- ST_CLEAR writes zero to one word per cycle, starting at word 0.
- ST_RUN serves lookups and host accesses.
- Reset always enters ST_CLEAR.
- Transition CLEAR_DONE (ST_CLEAR to ST_RUN) is taken on the cycle that clears the last word.
- ST_RUN holds until the next reset.

Top module: `mcf_filter`

## Requirements
- R1: After reset is released, `ready` is low for exactly 272 clock edges (17 banks of 16 words, one word per edge). It is high from then on until the next reset.
- R2: Once `ready` rises, every bitmap word reads zero and every lookup rejects, whatever was stored before the reset.
- R3: `dec_valid` is high in the cycle after a cycle with `lk_req` high, and low in the cycle after a cycle with `lk_req` low. `dec_accept` is only ever high together with `dec_valid`.
- R4: Net n maps to word n/16, bit n%16 of the selected bitmap. A lookup accepts exactly when that bit is 1. This holds for net 0 (word 0 bit 0) and for net 255 (word 15 bit 15).
- R5: When `lk_ctrl` is 1, the lookup uses bank 0 for any `lk_port`. When `lk_ctrl` is 0, bank 0 is never consulted.
- R6: With `cfg_full`=1, a data lookup from port p uses bank p+1.
- R7: With `cfg_full`=0 and `cfg_pair`=0, a data lookup from port p below 8 uses bank p+1, and a data lookup from port 8 to 15 always rejects.
- R8: With `cfg_full`=0 and `cfg_pair`=1, data lookups from ports 2k and 2k+1 both use bank k+1.
- R9: With `cfg_full`=0, host writes to banks 9 to 16 are dropped and host reads of them return 0. Host reads of banks above 16 return 0 in any mode.
- R10: While `ready` is low, every lookup returns reject with the valid strobe, and host writes are dropped.
- R11: A host read issued with `host_re` in one cycle returns the stored word on `host_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the clear sweep |
| cfg_full | input | 1 | 1: sixteen data bitmaps; 0: compact mode with eight |
| cfg_pair | input | 1 | Compact mode only: ports 2k and 2k+1 share bitmap k |
| host_addr | input | 9 | Host word address {bank[4:0], word[3:0]} |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 16 | Read data, one cycle after host_re |
| lk_req | input | 1 | Lookup request |
| lk_ctrl | input | 1 | 1: control cell; 0: data cell |
| lk_port | input | 4 | Arrival port of a data cell |
| lk_net | input | 8 | Multicast net number |
| ready | output | 1 | Bitmaps cleared; block serving |
| dec_valid | output | 1 | Decision strobe, one cycle after lk_req |
| dec_accept | output | 1 | Decision: 1 accept, 0 reject |

## Verification
The bench builds the block with its default parameters: eight-bit net numbers, sixteen-bit host words and sixteen data bitmaps. This puts both extreme net numbers (0 and 255) within reach. It also covers every port number in all three mapping arrangements, the dead upper half of the data space, and the out-of-range host banks.

With these parameters the full 272-word clear sweep is short enough to be timed exactly. It is also run a second time over bitmaps that were filled with data first.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } mcf_state_e;
endpackage

// File: rtl/mcf_init_seq.sv
module mcf_init_seq
    import mcf_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 272
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              clr_we,
    output logic [ADDR_W-1:0] clr_addr,
    output logic              ready
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    mcf_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (cnt_q == LAST) state_d = ST_RUN;   // CLEAR_DONE
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        clr_we   = 1'b0;
        ready    = 1'b0;
        clr_addr = cnt_q;
        unique case (state_q)
            ST_CLEAR: clr_we = 1'b1;
            ST_RUN:   ready  = 1'b1;
        endcase
    end
endmodule

// File: rtl/mcf_bank_map.sv
module mcf_bank_map #(
    parameter int DATA_BANKS = 16,
    parameter int PORT_W     = 4,
    parameter int BANK_W     = 5
) (
    input  logic              lk_ctrl,
    input  logic [PORT_W-1:0] lk_port,
    input  logic              cfg_full,
    input  logic              cfg_pair,
    input  logic [BANK_W-1:0] host_bank,
    output logic [BANK_W-1:0] lk_bank,
    output logic              lk_hit,
    output logic              host_ok
);
    localparam int HALF = DATA_BANKS / 2;
    localparam logic [BANK_W-1:0] ONE      = BANK_W'(1);
    localparam logic [BANK_W-1:0] TOP_FULL = BANK_W'(DATA_BANKS);
    localparam logic [BANK_W-1:0] TOP_HALF = BANK_W'(HALF);

    logic [BANK_W-1:0] port_ext;
    assign port_ext = BANK_W'(lk_port);

    always_comb begin
        lk_bank = '0;
        lk_hit  = 1'b1;
        if (lk_ctrl) begin
            lk_bank = '0;
        end else if (cfg_full) begin
            lk_bank = port_ext + ONE;
        end else if (cfg_pair) begin
            lk_bank = (port_ext >> 1) + ONE;
        end else if (port_ext < TOP_HALF) begin
            lk_bank = port_ext + ONE;
        end else begin
            lk_hit  = 1'b0;
        end
    end

    assign host_ok = (host_bank <= (cfg_full ? TOP_FULL : TOP_HALF));
endmodule

// File: rtl/mcf_bitmap_ram.sv
module mcf_bitmap_ram #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 272,
    parameter int NRD    = 2
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [WORD_W-1:0]             wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]    raddr,
    output logic [NRD-1:0][WORD_W-1:0]    rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < ADDR_W'(DEPTH))) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] < ADDR_W'(DEPTH)) ? mem[raddr[g]] : '0;
    end
endmodule

// File: rtl/mcf_filter.sv
module mcf_filter #(
    parameter int NET_W      = 8,
    parameter int WORD_W     = 16,
    parameter int DATA_BANKS = 16,
    parameter int PORT_W     = $clog2(DATA_BANKS),
    parameter int WIDX_W     = NET_W - $clog2(WORD_W),
    parameter int BANK_W     = $clog2(DATA_BANKS + 1),
    parameter int ADDR_W     = BANK_W + WIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_full,
    input  logic              cfg_pair,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_re,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              lk_req,
    input  logic              lk_ctrl,
    input  logic [PORT_W-1:0] lk_port,
    input  logic [NET_W-1:0]  lk_net,
    output logic              ready,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int BIT_W          = $clog2(WORD_W);
    localparam int WORDS_PER_BANK = 1 << WIDX_W;
    localparam int DEPTH          = (DATA_BANKS + 1) * WORDS_PER_BANK;

    logic              clr_we;
    logic [ADDR_W-1:0] clr_addr;
    logic [BANK_W-1:0] lk_bank;
    logic              lk_hit, host_ok;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [WORD_W-1:0] ram_wdata;
    logic [1:0][ADDR_W-1:0] rd_addr;
    logic [1:0][WORD_W-1:0] rd_data;
    logic              bit_val;

    mcf_init_seq #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .clr_we(clr_we), .clr_addr(clr_addr), .ready(ready)
    );

    mcf_bank_map #(.DATA_BANKS(DATA_BANKS), .PORT_W(PORT_W), .BANK_W(BANK_W)) u_map (
        .lk_ctrl(lk_ctrl), .lk_port(lk_port),
        .cfg_full(cfg_full), .cfg_pair(cfg_pair),
        .host_bank(host_addr[ADDR_W-1:WIDX_W]),
        .lk_bank(lk_bank), .lk_hit(lk_hit), .host_ok(host_ok)
    );

    // clear sweep owns the write port until ready
    assign ram_we    = clr_we | (host_we & ready & host_ok);
    assign ram_waddr = clr_we ? clr_addr : host_addr;
    assign ram_wdata = clr_we ? '0 : host_wdata;

    assign rd_addr[0] = {lk_bank, lk_net[NET_W-1:BIT_W]};
    assign rd_addr[1] = host_addr;

    mcf_bitmap_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .NRD(2)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign bit_val = rd_data[0][lk_net[BIT_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            host_rdata <= '0;
        end else begin
            dec_valid  <= lk_req;
            dec_accept <= lk_req & ready & lk_hit & bit_val;
            if (host_re) host_rdata <= (ready && host_ok) ? rd_data[1] : '0;
        end
    end
endmodule

// File: rtl/mcf_filter_chk.sv
module mcf_filter_chk #(
    parameter int ADDR_W     = 9,
    parameter int WORD_W     = 16,
    parameter int PORT_W     = 4,
    parameter int WIDX_W     = 4,
    parameter int DATA_BANKS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_full,
    input logic              cfg_pair,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_re,
    input logic [WORD_W-1:0] host_rdata,
    input logic              lk_req,
    input logic              lk_ctrl,
    input logic [PORT_W-1:0] lk_port,
    input logic              ready,
    input logic              dec_valid,
    input logic              dec_accept
);
    localparam int HALF = DATA_BANKS / 2;
    logic [ADDR_W-WIDX_W-1:0] hbank;
    assign hbank = host_addr[ADDR_W-1:WIDX_W];

    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    a_r3_valid_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> dec_valid);
    a_r3_quiet_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !dec_valid);
    a_r3_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);
    a_r10_reject_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !ready) |=> (dec_valid && !dec_accept));
    a_r7_upper_ports_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_ctrl && !cfg_full && !cfg_pair && (int'(lk_port) >= HALF))
        |=> !dec_accept);
    a_r9_dead_bank_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && ((!cfg_full && int'(hbank) > HALF) || int'(hbank) > DATA_BANKS))
        |=> (host_rdata == '0));
endmodule

bind mcf_filter mcf_filter_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PORT_W(PORT_W),
    .WIDX_W(WIDX_W), .DATA_BANKS(DATA_BANKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_full(cfg_full), .cfg_pair(cfg_pair),
    .host_addr(host_addr), .host_re(host_re), .host_rdata(host_rdata),
    .lk_req(lk_req), .lk_ctrl(lk_ctrl), .lk_port(lk_port),
    .ready(ready), .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/mcf_filter_test.sv
`timescale 1ns/1ps
module mcf_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_full = 1'b1, cfg_pair = 1'b0;
    logic [8:0]  host_addr = '0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        lk_req = 1'b0, lk_ctrl = 1'b0;
    logic [3:0]  lk_port = '0;
    logic [7:0]  lk_net = '0;
    logic        ready, dec_valid, dec_accept;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mcf_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_full(cfg_full), .cfg_pair(cfg_pair),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
        .host_re(host_re), .host_rdata(host_rdata),
        .lk_req(lk_req), .lk_ctrl(lk_ctrl), .lk_port(lk_port), .lk_net(lk_net),
        .ready(ready), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input int bank, input int word, input logic [15:0] d);
        @(negedge clk);
        host_addr = {bank[4:0], word[3:0]}; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input int bank, input int word, output logic [15:0] d);
        @(negedge clk);
        host_addr = {bank[4:0], word[3:0]}; host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    task automatic lookup(input bit ctrl, input int port, input int net,
                          output bit v, output bit a);
        @(negedge clk);
        lk_req = 1'b1; lk_ctrl = ctrl; lk_port = port[3:0]; lk_net = net[7:0];
        @(negedge clk);
        lk_req = 1'b0;
        v = dec_valid; a = dec_accept;
    endtask

    task automatic expect_lk(input string req, input bit ctrl, input int port,
                             input int net, input bit exp);
        bit v, a;
        lookup(ctrl, port, net, v, a);
        check(v == 1'b1, req, v, 1);
        check(a == exp, req, a, exp);
    endtask

    task automatic expect_rd(input string req, input int bank, input int word,
                             input logic [15:0] exp);
        logic [15:0] d;
        hread(bank, word, d);
        check(d == exp, req, d, exp);
    endtask

    // R1, R10: reset state, clear sweep length, early lookups and writes
    task automatic t_reset_sweep();
        int n;
        bit v, a;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(ready == 1'b0 && dec_valid == 1'b0, "R1 reset state", {ready, dec_valid}, 0);
        rst_n = 1'b1;
        n = 0;
        repeat (4) begin @(negedge clk); n++; end
        hwrite(0, 0, 16'hFFFF);               // R10 write while clearing
        n += 2;
        lookup(1'b1, 0, 0, v, a);             // R10 lookup while clearing
        n += 2;
        check(v == 1'b1 && a == 1'b0, "R10 early lookup", {v, a}, 2);
        while (!ready && n < 400) begin @(negedge clk); n++; end
        check(n == 272, "R1 sweep length", n, 272);
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R1 ready holds", ready, 1);
        expect_rd("R10 early write dropped", 0, 0, 16'h0000);
    endtask

    // R3, R4, R11
    task automatic t_bitmap();
        cfg_full = 1'b1; cfg_pair = 1'b0;
        hwrite(0, 0, 16'h0001);
        hwrite(0, 3, 16'h0020);
        hwrite(0, 15, 16'h8000);
        expect_rd("R11 readback", 0, 3, 16'h0020);
        expect_lk("R4 net0", 1'b1, 0, 0, 1'b1);
        expect_lk("R4 net255", 1'b1, 0, 255, 1'b1);
        expect_lk("R4 net53", 1'b1, 0, 53, 1'b1);
        expect_lk("R4 net52", 1'b1, 0, 52, 1'b0);
        expect_lk("R4 net54", 1'b1, 0, 54, 1'b0);
        expect_lk("R4 net254", 1'b1, 0, 254, 1'b0);
        @(negedge clk);
        check(dec_valid == 1'b0, "R3 no strobe when idle", dec_valid, 0);
    endtask

    // R5
    task automatic t_ctrl();
        expect_lk("R5 ctrl any port", 1'b1, 9, 53, 1'b1);
        expect_lk("R5 data ignores bank0", 1'b0, 0, 53, 1'b0);
    endtask

    // R6
    task automatic t_full();
        cfg_full = 1'b1;
        hwrite(10, 2, 16'h0100);   // data bank 9, net 40
        hwrite(12, 7, 16'h0004);   // data bank 11, net 114
        hwrite(4, 7, 16'h0004);    // data bank 3, net 114
        expect_lk("R6 port9 net40", 1'b0, 9, 40, 1'b1);
        expect_lk("R6 port8 net40", 1'b0, 8, 40, 1'b0);
        expect_lk("R6 port11 net114", 1'b0, 11, 114, 1'b1);
        expect_lk("R6 ctrl net40", 1'b1, 9, 40, 1'b0);
    endtask

    // R7
    task automatic t_compact();
        cfg_full = 1'b0; cfg_pair = 1'b0;
        expect_lk("R7 port3 net114", 1'b0, 3, 114, 1'b1);
        expect_lk("R7 port2 net114", 1'b0, 2, 114, 1'b0);
        expect_lk("R7 port11 rejects", 1'b0, 11, 114, 1'b0);
        expect_lk("R7 port9 rejects", 1'b0, 9, 40, 1'b0);
    endtask

    // R8
    task automatic t_pair();
        cfg_full = 1'b0; cfg_pair = 1'b1;
        expect_lk("R8 port6 shares bank3", 1'b0, 6, 114, 1'b1);
        expect_lk("R8 port7 shares bank3", 1'b0, 7, 114, 1'b1);
        expect_lk("R8 port3 uses bank1", 1'b0, 3, 114, 1'b0);
        expect_lk("R8 port15 uses bank7", 1'b0, 15, 114, 1'b0);
    endtask

    // R9
    task automatic t_dead_region();
        cfg_full = 1'b0; cfg_pair = 1'b0;
        hwrite(13, 0, 16'hFFFF);
        expect_rd("R9 dead bank read", 13, 0, 16'h0000);
        expect_rd("R9 dead bank keeps data hidden", 12, 7, 16'h0000);
        expect_rd("R9 live bank read", 4, 7, 16'h0004);
        cfg_full = 1'b1;
        expect_rd("R9 dead write dropped", 13, 0, 16'h0000);
        expect_rd("R9 stored data kept", 12, 7, 16'h0004);
        expect_rd("R9 bank above range", 20, 0, 16'h0000);
    endtask

    // R2
    task automatic t_reclear();
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!ready && n < 400) begin @(negedge clk); n++; end
        check(n == 272, "R2 second sweep", n, 272);
        expect_rd("R2 ctrl word cleared", 0, 3, 16'h0000);
        expect_rd("R2 data word cleared", 4, 7, 16'h0000);
        expect_lk("R2 ctrl lookup rejects", 1'b1, 0, 53, 1'b0);
        expect_lk("R2 data lookup rejects", 1'b0, 11, 114, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_sweep();
        t_bitmap();
        t_ctrl();
        t_full();
        t_compact();
        t_pair();
        t_dead_region();
        t_reclear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule